// File: doc/BRIEF.md
# Serial Panel Power-Up Sequencer

This block brings a small TFT panel controller out of power-up so that the panel will accept a parallel RGB pixel stream from another device. On a start pulse it drives the panel's active-low reset line low, releases it, waits, and then sends a fixed script of command bytes and parameter bytes over a 4-wire serial link. The link has a chip select, a serial clock, a serial data line and a separate line that marks each byte as a command or a parameter. Waits measured in milliseconds separate the reset phases and follow the two last commands. A parameterised divider turns the system clock into a millisecond tick.

When the script has finished, the block raises a sticky done flag, parks the serial bus idle and flips a routing output. That output steers the shared chip select to the other device on the bus, and the panel receives no further serial traffic until the next system reset. The script covers memory access control, an 18-bit pixel format, inversion on, RAM control, RGB interface control, display on and sleep out.

Top module: `panel_boot_seq`

## Requirements
- R1: While `rst_n` is low and afterwards until `start` is seen, `panel_rst_n`=1, `panel_cs_n`=1, `panel_sclk`=0, `panel_mosi`=0, `busy`=0, `done`=0 and `cs_route`=0.
- R2: A `start` pulse in idle drives `panel_rst_n` low for exactly RESET_LOW_MS×CLK_PER_MS cycles. After that it goes high, and the first chip-select fall comes RESET_WAIT_MS×CLK_PER_MS cycles (plus at most 4) after the rise.
- R3: The panel receives exactly 14 bytes, in this order: 0x36, 0x00, 0x3A, 0x66, 0x21, 0xB0, 0x11, 0xC2, 0xB1, 0x40, 0x08, 0x14, 0x29, 0x11.
- R4: `panel_dc` is 0 during every command byte and 1 during every parameter byte, and it holds one value over all eight rising clock edges of a byte. The command bytes are positions 0, 2, 4, 5, 8, 12 and 13 of R3.
- R5: Chip select is low for the whole of each command and its parameters, which gives 7 low windows: {0x36,0x00}, {0x3A,0x66}, {0x21}, {0xB0,0x11,0xC2}, {0xB1,0x40,0x08,0x14}, {0x29}, {0x11}. It is high for at least 2 cycles between windows, and no byte is cut by a select edge.
- R6: The link runs in SPI mode 0 and sends MSB first. `panel_sclk` idles low, data is sampled on the rising edge, `panel_mosi` changes only while the clock is low, and the select changes only while the clock is low.
- R7: After the display-on window closes, the next window opens no sooner than DISPLAY_ON_MS×CLK_PER_MS cycles later. After the sleep-out window closes, `done` rises no sooner than SLEEP_OUT_MS×CLK_PER_MS cycles later.
- R8: At the end of the script `done`=1, `busy`=0 and `cs_route`=1 (the select now belongs to the other device), with the bus idle (`panel_cs_n`=1, `panel_sclk`=0). This state holds until reset.
- R9: A `start` pulse while `busy` is 1 has no effect: the reset line falls once and the byte stream is unchanged.
- R10: A `start` pulse after `done` has no effect: no reset pulse, no serial clock edge, and `done` stays 1.
- R11: `busy` is 1 from the cycle after an accepted `start` until `done` rises, and `busy` and `done` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the power-up sequence (accepted only in idle) |
| panel_rst_n | output | 1 | Active-low reset to the panel controller |
| panel_cs_n | output | 1 | Active-low serial chip select for the panel |
| panel_sclk | output | 1 | Serial clock, idles low |
| panel_mosi | output | 1 | Serial data, MSB first |
| panel_dc | output | 1 | 0 = command byte, 1 = parameter byte |
| cs_route | output | 1 | 0 = shared select routed to panel, 1 = routed to the other device |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
The hardest behaviour to reach from the ports is a `start` pulse that arrives in the middle of a phase: during the reset-low hold, during the post-reset wait, and in the middle of a serial byte. A pulse at any of these points must leave the timing and the byte stream unchanged. The bench shortens the millisecond tick through the divider parameter so that the full 300 ms of waits fits in a few thousand cycles. It then places start pulses at fixed cycle offsets that fall inside each of these phases. A port monitor rebuilds every byte, its command/parameter flag and its select window, and records the cycle of every select edge. This lets the bench compare both the long waits and the short gaps against bounds worked out from the parameters.

// File: rtl/panel_boot_pkg.sv
package panel_boot_pkg;

    // wait attached to the end of a select window
    typedef enum logic [1:0] {
        WAIT_NONE,
        WAIT_AFTER_ON,
        WAIT_AFTER_WAKE
    } hold_sel_e;

    typedef struct packed {
        logic [7:0] code;
        logic       is_param;
        logic       grp_end;
        hold_sel_e  hold;
        logic       final_step;
    } step_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_WAIT,
        ST_LOAD,
        ST_SHIFT,
        ST_GAP,
        ST_HOLD,
        ST_DONE
    } seq_st_e;

    localparam int SCRIPT_LEN = 14;

    localparam logic [7:0] OP_MEM_ACCESS = 8'h36;
    localparam logic [7:0] OP_PIX_FMT    = 8'h3A;
    localparam logic [7:0] OP_INV_ON     = 8'h21;
    localparam logic [7:0] OP_RAM_CTL    = 8'hB0;
    localparam logic [7:0] OP_RGB_CTL    = 8'hB1;
    localparam logic [7:0] OP_DISP_ON    = 8'h29;
    localparam logic [7:0] OP_WAKE       = 8'h11;

endpackage

// File: rtl/ms_tick.sv
module ms_tick #(
    parameter int CLK_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = !clr && (cnt_q == LAST);

endmodule

// File: rtl/boot_script_rom.sv
module boot_script_rom
    import panel_boot_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic [IW-1:0] idx,
    output step_t         step
);
    function automatic step_t mk(input logic [7:0] c, input logic p, input logic e,
                                 input hold_sel_e h, input logic f);
        step_t s;
        s.code       = c;
        s.is_param   = p;
        s.grp_end    = e;
        s.hold       = h;
        s.final_step = f;
        return s;
    endfunction

    always_comb begin
        unique case (idx)
            IW'(0):  step = mk(OP_MEM_ACCESS, 1'b0, 1'b0, WAIT_NONE,       1'b0);
            IW'(1):  step = mk(8'h00,         1'b1, 1'b1, WAIT_NONE,       1'b0);
            IW'(2):  step = mk(OP_PIX_FMT,    1'b0, 1'b0, WAIT_NONE,       1'b0);
            IW'(3):  step = mk(8'h66,         1'b1, 1'b1, WAIT_NONE,       1'b0);
            IW'(4):  step = mk(OP_INV_ON,     1'b0, 1'b1, WAIT_NONE,       1'b0);
            IW'(5):  step = mk(OP_RAM_CTL,    1'b0, 1'b0, WAIT_NONE,       1'b0);
            IW'(6):  step = mk(8'h11,         1'b1, 1'b0, WAIT_NONE,       1'b0);
            IW'(7):  step = mk(8'hC2,         1'b1, 1'b1, WAIT_NONE,       1'b0);
            IW'(8):  step = mk(OP_RGB_CTL,    1'b0, 1'b0, WAIT_NONE,       1'b0);
            IW'(9):  step = mk(8'h40,         1'b1, 1'b0, WAIT_NONE,       1'b0);
            IW'(10): step = mk(8'h08,         1'b1, 1'b0, WAIT_NONE,       1'b0);
            IW'(11): step = mk(8'h14,         1'b1, 1'b1, WAIT_NONE,       1'b0);
            IW'(12): step = mk(OP_DISP_ON,    1'b0, 1'b1, WAIT_AFTER_ON,   1'b0);
            IW'(13): step = mk(OP_WAKE,       1'b0, 1'b1, WAIT_AFTER_WAKE, 1'b1);
            default: step = mk(8'h00,         1'b0, 1'b1, WAIT_NONE,       1'b1);
        endcase
    end

endmodule

// File: rtl/ser8_tx.sv
module ser8_tx #(
    parameter int SCLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] byte_in,
    output logic       sclk,
    output logic       mosi,
    output logic       fin
);
    localparam int HW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [HW-1:0] HLAST = HW'(SCLK_HALF - 1);

    typedef struct packed {
        logic          active;
        logic [3:0]    bits;
        logic [HW-1:0] cnt;
        logic [7:0]    sh;
        logic          sclk;
        logic          fin;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d     = tx_q;
        tx_d.fin = 1'b0;
        if (load) begin
            tx_d.active = 1'b1;
            tx_d.bits   = 4'd8;
            tx_d.cnt    = '0;
            tx_d.sh     = byte_in;
            tx_d.sclk   = 1'b0;
        end else if (tx_q.active) begin
            if (tx_q.cnt == HLAST) begin
                tx_d.cnt = '0;
                if (!tx_q.sclk) begin
                    tx_d.sclk = 1'b1;
                end else begin
                    tx_d.sclk = 1'b0;
                    tx_d.sh   = {tx_q.sh[6:0], 1'b0};
                    tx_d.bits = tx_q.bits - 4'd1;
                    if (tx_q.bits == 4'd1) begin
                        tx_d.active = 1'b0;
                        tx_d.fin    = 1'b1;
                    end
                end
            end else begin
                tx_d.cnt = tx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign sclk = tx_q.sclk;
    assign mosi = tx_q.active & tx_q.sh[7];
    assign fin  = tx_q.fin;

endmodule

// File: rtl/panel_boot_seq.sv
module panel_boot_seq
    import panel_boot_pkg::*;
#(
    parameter int CLK_PER_MS    = 50000,
    parameter int SCLK_HALF     = 2,
    parameter int RESET_LOW_MS  = 50,
    parameter int RESET_WAIT_MS = 50,
    parameter int DISPLAY_ON_MS = 100,
    parameter int SLEEP_OUT_MS  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic panel_rst_n,
    output logic panel_cs_n,
    output logic panel_sclk,
    output logic panel_mosi,
    output logic panel_dc,
    output logic cs_route,
    output logic busy,
    output logic done
);
    localparam int IW      = $clog2(SCRIPT_LEN);
    localparam int MAX_A   = (RESET_LOW_MS > RESET_WAIT_MS) ? RESET_LOW_MS : RESET_WAIT_MS;
    localparam int MAX_B   = (DISPLAY_ON_MS > SLEEP_OUT_MS) ? DISPLAY_ON_MS : SLEEP_OUT_MS;
    localparam int MAX_MS  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MSW     = $clog2(MAX_MS + 1);
    localparam int GAP_CYC = 2 * SCLK_HALF;
    localparam int GW      = $clog2(GAP_CYC + 1);

    typedef struct packed {
        seq_st_e        st;
        logic [IW-1:0]  idx;
        logic [MSW-1:0] ms_left;
        logic [GW-1:0]  gap;
        logic           rst_n;
        logic           cs_n;
        logic           dc;
        logic           route;
        logic           busy;
        logic           done;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        st: ST_IDLE, idx: '0, ms_left: '0, gap: '0,
        rst_n: 1'b1, cs_n: 1'b1, dc: 1'b0, route: 1'b0, busy: 1'b0, done: 1'b0
    };

    ctl_t  c_d, c_q;
    step_t step;
    logic  tick, tick_clr, tx_load, tx_fin;

    ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    boot_script_rom #(.IW(IW)) u_rom (
        .idx  (c_q.idx),
        .step (step)
    );

    ser8_tx #(.SCLK_HALF(SCLK_HALF)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tx_load),
        .byte_in (step.code),
        .sclk    (panel_sclk),
        .mosi    (panel_mosi),
        .fin     (tx_fin)
    );

    // the divider runs only in the three waiting states and restarts on entry
    assign tick_clr = !(c_q.st == ST_RST_LOW || c_q.st == ST_RST_WAIT || c_q.st == ST_HOLD);

    always_comb begin
        c_d     = c_q;
        tx_load = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st      = ST_RST_LOW;
                    c_d.rst_n   = 1'b0;
                    c_d.busy    = 1'b1;
                    c_d.ms_left = MSW'(RESET_LOW_MS);
                end
            end
            ST_RST_LOW: begin
                if (tick) begin
                    if (c_q.ms_left == MSW'(1)) begin
                        c_d.st      = ST_RST_WAIT;
                        c_d.rst_n   = 1'b1;
                        c_d.ms_left = MSW'(RESET_WAIT_MS);
                    end else begin
                        c_d.ms_left = c_q.ms_left - 1'b1;
                    end
                end
            end
            ST_RST_WAIT: begin
                if (tick) begin
                    if (c_q.ms_left == MSW'(1)) begin
                        c_d.st   = ST_LOAD;
                        c_d.idx  = '0;
                        c_d.cs_n = 1'b0;
                    end else begin
                        c_d.ms_left = c_q.ms_left - 1'b1;
                    end
                end
            end
            ST_LOAD: begin
                tx_load  = 1'b1;
                c_d.dc   = step.is_param;
                c_d.cs_n = 1'b0;
                c_d.st   = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (tx_fin) begin
                    if (step.grp_end) begin
                        c_d.st   = ST_GAP;
                        c_d.cs_n = 1'b1;
                        c_d.gap  = '0;
                    end else begin
                        c_d.idx = c_q.idx + 1'b1;
                        c_d.st  = ST_LOAD;
                    end
                end
            end
            ST_GAP: begin
                if (c_q.gap == GW'(GAP_CYC - 1)) begin
                    if (step.hold != WAIT_NONE) begin
                        c_d.st      = ST_HOLD;
                        c_d.ms_left = (step.hold == WAIT_AFTER_ON) ? MSW'(DISPLAY_ON_MS)
                                                                   : MSW'(SLEEP_OUT_MS);
                    end else if (step.final_step) begin
                        c_d.st    = ST_DONE;
                        c_d.busy  = 1'b0;
                        c_d.done  = 1'b1;
                        c_d.route = 1'b1;
                        c_d.dc    = 1'b0;
                    end else begin
                        c_d.idx  = c_q.idx + 1'b1;
                        c_d.st   = ST_LOAD;
                        c_d.cs_n = 1'b0;
                    end
                end else begin
                    c_d.gap = c_q.gap + 1'b1;
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    if (c_q.ms_left == MSW'(1)) begin
                        if (step.final_step) begin
                            c_d.st    = ST_DONE;
                            c_d.busy  = 1'b0;
                            c_d.done  = 1'b1;
                            c_d.route = 1'b1;
                            c_d.dc    = 1'b0;
                        end else begin
                            c_d.idx  = c_q.idx + 1'b1;
                            c_d.st   = ST_LOAD;
                            c_d.cs_n = 1'b0;
                        end
                    end else begin
                        c_d.ms_left = c_q.ms_left - 1'b1;
                    end
                end
            end
            ST_DONE: begin
                c_d = c_q;
            end
            default: begin
                c_d = CTL_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= CTL_RESET;
        end else begin
            c_q <= c_d;
        end
    end

    assign panel_rst_n = c_q.rst_n;
    assign panel_cs_n  = c_q.cs_n;
    assign panel_dc    = c_q.dc;
    assign cs_route    = c_q.route;
    assign busy        = c_q.busy;
    assign done        = c_q.done;

endmodule

// File: rtl/panel_boot_seq_chk.sv
module panel_boot_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic panel_rst_n,
    input logic panel_cs_n,
    input logic panel_sclk,
    input logic panel_mosi,
    input logic panel_dc,
    input logic cs_route,
    input logic busy,
    input logic done
);
    // R2: the panel is held in reset only inside a running sequence, with the bus quiet
    a_r2_rst_low_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n |-> (busy && panel_cs_n));

    // R5: select is low only after the panel left reset and while running
    a_r5_cs_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_cs_n |-> (panel_rst_n && busy));

    // R6: serial clock stays low whenever the panel is not selected
    a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        panel_cs_n |-> !panel_sclk);

    // R6: data does not move during a clock-high phase
    a_r6_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (panel_sclk && $past(panel_sclk)) |-> $stable(panel_mosi));

    // R4: command/parameter line is steady while the clock is high
    a_r4_dc_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        panel_sclk |-> $stable(panel_dc));

    // R8: completion is sticky and keeps the select routed away
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && cs_route));

    // R10: no panel activity after completion
    a_r10_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (panel_cs_n && !panel_sclk && panel_rst_n));

    // R11: busy and done are exclusive
    a_r11_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R11: an idle block accepts start on the next edge
    a_r11_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

endmodule

bind panel_boot_seq panel_boot_seq_chk u_chk (.*);

// File: tb/panel_boot_seq_test.sv
module panel_boot_seq_test;

    localparam int T_CPM   = 20;
    localparam int T_HALF  = 2;
    localparam int LOW_CYC = 50 * T_CPM;
    localparam int WT_CYC  = 50 * T_CPM;
    localparam int ON_CYC  = 100 * T_CPM;
    localparam int WK_CYC  = 100 * T_CPM;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic panel_rst_n, panel_cs_n, panel_sclk, panel_mosi, panel_dc;
    logic cs_route, busy, done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    panel_boot_seq #(
        .CLK_PER_MS    (T_CPM),
        .SCLK_HALF     (T_HALF),
        .RESET_LOW_MS  (50),
        .RESET_WAIT_MS (50),
        .DISPLAY_ON_MS (100),
        .SLEEP_OUT_MS  (100)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .panel_rst_n (panel_rst_n),
        .panel_cs_n  (panel_cs_n),
        .panel_sclk  (panel_sclk),
        .panel_mosi  (panel_mosi),
        .panel_dc    (panel_dc),
        .cs_route    (cs_route),
        .busy        (busy),
        .done        (done)
    );

    // expected script
    logic [7:0] exp_val [0:13] = '{8'h36, 8'h00, 8'h3A, 8'h66, 8'h21, 8'hB0, 8'h11,
                                   8'hC2, 8'hB1, 8'h40, 8'h08, 8'h14, 8'h29, 8'h11};
    logic       exp_dc  [0:13] = '{0, 1, 0, 1, 0, 0, 1, 1, 0, 1, 1, 1, 0, 0};
    int         exp_grp [0:13] = '{0, 0, 1, 1, 2, 3, 3, 3, 4, 4, 4, 4, 5, 6};

    // port monitor, sampled on the falling clock edge
    logic       mon_clr = 1'b0;
    int         cyc, nbytes, bitn, gi, mode_err, dc_err, busy_err;
    int         rst_falls, rst_fall_c, rst_rise_c, done_c, sclk_rises;
    logic [7:0] cur;
    logic       dc0;
    logic [7:0] rv [0:31];
    logic       rd [0:31];
    int         rg [0:31];
    int         fall_c [0:15];
    int         rise_c [0:15];
    logic       p_sclk, p_cs, p_rst, p_done, p_mosi;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_clr) begin
            nbytes = 0; bitn = 0; gi = 0; mode_err = 0; dc_err = 0; busy_err = 0;
            rst_falls = 0; rst_fall_c = 0; rst_rise_c = 0; done_c = 0; sclk_rises = 0;
            cur = 8'h00; dc0 = 1'b0;
            for (int i = 0; i < 16; i++) begin
                fall_c[i] = 0;
                rise_c[i] = 0;
            end
        end else begin
            if (!p_sclk && panel_sclk) begin
                sclk_rises = sclk_rises + 1;
                cur = {cur[6:0], panel_mosi};
                if (bitn == 0) dc0 = panel_dc;
                else if (panel_dc != dc0) dc_err = dc_err + 1;
                if (panel_cs_n) mode_err = mode_err + 1;
                bitn = bitn + 1;
                if (bitn == 8) begin
                    if (nbytes < 32) begin
                        rv[nbytes] = cur;
                        rd[nbytes] = dc0;
                        rg[nbytes] = gi;
                    end
                    nbytes = nbytes + 1;
                    bitn = 0;
                end
            end
            if (p_sclk && panel_sclk && (panel_mosi != p_mosi)) mode_err = mode_err + 1;
            if ((panel_cs_n != p_cs) && (panel_sclk || p_sclk)) mode_err = mode_err + 1;
            if (p_cs && !panel_cs_n && gi < 16) fall_c[gi] = cyc;
            if (!p_cs && panel_cs_n) begin
                if (gi < 16) rise_c[gi] = cyc;
                gi = gi + 1;
                if (bitn != 0) mode_err = mode_err + 1;
            end
            if (p_rst && !panel_rst_n) begin
                rst_falls = rst_falls + 1;
                rst_fall_c = cyc;
            end
            if (!p_rst && panel_rst_n) rst_rise_c = cyc;
            if (!p_done && done) done_c = cyc;
            if (busy && done) busy_err = busy_err + 1;
        end
        p_sclk = panel_sclk;
        p_cs   = panel_cs_n;
        p_rst  = panel_rst_n;
        p_done = done;
        p_mosi = panel_mosi;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst_n   = 1'b0;
        start   = 1'b0;
        mon_clr = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R8 done reached", int'(done), 1);
    endtask

    task automatic check_script(input string tag);
        int vmis = 0, dmis = 0, gmis = 0;
        chk(nbytes == 14, {"R3 byte count ", tag}, nbytes, 14);
        for (int i = 0; i < 14; i++) begin
            if (i < nbytes) begin
                if (rv[i] != exp_val[i]) begin
                    vmis++;
                    $display("FAIL R3 byte %0d actual=%0h expected=%0h", i, rv[i], exp_val[i]);
                end
                if (rd[i] != exp_dc[i]) dmis++;
                if (rg[i] != exp_grp[i]) gmis++;
            end
        end
        chk(vmis == 0, {"R3 byte values ", tag}, vmis, 0);
        chk(dmis == 0 && dc_err == 0, {"R4 command/parameter flag ", tag}, dmis + dc_err, 0);
        chk(gi == 7 && gmis == 0, {"R5 select windows ", tag}, gi * 100 + gmis, 700);
        for (int g = 0; g < 5; g++) begin
            chk((fall_c[g + 1] - rise_c[g]) >= 2 && (fall_c[g + 1] - rise_c[g]) <= 40,
                {"R5 gap between windows ", tag}, fall_c[g + 1] - rise_c[g], 4);
        end
        chk(mode_err == 0, {"R6 mode 0 edges ", tag}, mode_err, 0);
        chk((rst_rise_c - rst_fall_c) >= LOW_CYC - 2 && (rst_rise_c - rst_fall_c) <= LOW_CYC + 2,
            {"R2 reset low time ", tag}, rst_rise_c - rst_fall_c, LOW_CYC);
        chk((fall_c[0] - rst_rise_c) >= WT_CYC && (fall_c[0] - rst_rise_c) <= WT_CYC + 4,
            {"R2 wait before first command ", tag}, fall_c[0] - rst_rise_c, WT_CYC);
        chk((fall_c[6] - rise_c[5]) >= ON_CYC && (fall_c[6] - rise_c[5]) <= ON_CYC + 10,
            {"R7 wait after display on ", tag}, fall_c[6] - rise_c[5], ON_CYC);
        chk((done_c - rise_c[6]) >= WK_CYC && (done_c - rise_c[6]) <= WK_CYC + 10,
            {"R7 wait after sleep out ", tag}, done_c - rise_c[6], WK_CYC);
        chk(busy_err == 0, {"R11 busy and done exclusive ", tag}, busy_err, 0);
    endtask

    task automatic check_finished(input string tag);
        chk(done == 1'b1 && busy == 1'b0, {"R8 done set, busy clear ", tag},
            {30'd0, done, busy}, 2);
        chk(cs_route == 1'b1, {"R8 select routed away ", tag}, int'(cs_route), 1);
        chk(panel_cs_n == 1'b1 && panel_sclk == 1'b0, {"R8 bus idle ", tag},
            {30'd0, panel_cs_n, panel_sclk}, 2);
    endtask

    // scenario: outputs under reset and in idle
    task automatic t_reset_state();
        rst_n = 1'b0;
        mon_clr = 1'b1;
        repeat (3) @(negedge clk);
        chk(panel_rst_n && panel_cs_n && !panel_sclk && !panel_mosi && !busy && !done && !cs_route,
            "R1 outputs in reset", {25'd0, panel_rst_n, panel_cs_n, panel_sclk, panel_mosi,
                                    busy, done, cs_route}, 96);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        mon_clr = 1'b0;
        repeat (50) @(negedge clk);
        chk(panel_rst_n && panel_cs_n && !busy && !done && !cs_route && sclk_rises == 0,
            "R1 idle without start", sclk_rises, 0);
    endtask

    // scenario: one plain run
    task automatic t_boot_basic();
        apply_reset();
        pulse_start();
        chk(busy == 1'b1 && panel_rst_n == 1'b0, "R11 busy after start",
            {30'd0, busy, panel_rst_n}, 2);
        repeat (LOW_CYC / 2) @(negedge clk);
        chk(busy == 1'b1, "R11 busy during reset hold", int'(busy), 1);
        wait_done();
        repeat (5) @(negedge clk);
        check_script("basic");
        check_finished("basic");
    endtask

    // scenario: start pulses inside each phase of a running sequence
    task automatic t_start_while_busy();
        apply_reset();
        pulse_start();
        repeat (200) @(negedge clk);
        pulse_start();
        repeat (LOW_CYC + 100) @(negedge clk);
        pulse_start();
        repeat (WT_CYC - 290 + 15) @(negedge clk);
        pulse_start();
        wait_done();
        repeat (5) @(negedge clk);
        chk(rst_falls == 1, "R9 single reset pulse", rst_falls, 1);
        check_script("restart");
        check_finished("restart");
    endtask

    // scenario: start after completion
    task automatic t_start_after_done();
        int bytes0, rises0, falls0;
        bytes0 = nbytes;
        rises0 = sclk_rises;
        falls0 = rst_falls;
        pulse_start();
        repeat (3000) @(negedge clk);
        chk(rst_falls == falls0 && panel_rst_n == 1'b1, "R10 no reset after done",
            rst_falls - falls0, 0);
        chk(sclk_rises == rises0 && nbytes == bytes0, "R10 no serial traffic after done",
            sclk_rises - rises0, 0);
        chk(done == 1'b1 && busy == 1'b0 && cs_route == 1'b1, "R10 done held",
            {29'd0, done, busy, cs_route}, 5);
    endtask

    initial begin
        t_reset_state();
        t_boot_basic();
        t_start_while_busy();
        t_start_after_done();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule